// File: doc/BRIEF.md
# Continuously Variable Slope Delta Voice Encoder

This block turns a stream of 16-bit signed voice samples into a one-bit-per-sample delta code. Samples normally arrive at 32 kHz, each marked by a single-cycle valid strobe. For every sample the block compares the input against its own running prediction and emits a 1 when the input is at or above the prediction and a 0 when it is below. The prediction then moves up or down by the current step size.

The step size adapts to the signal. When the newest bit and the two bits before it all agree, the waveform is outrunning the prediction, so the step is decayed and then boosted by a fixed base amount. Otherwise the step only decays, and a floor stops it from vanishing. All arithmetic is Q15, where full scale is 1.0. The decay factor is 28016/32768, about 0.855. The base step is 1409, about 0.043 of full scale. The prediction saturates at the 16-bit signed limits and never wraps.

A decoder that runs the same step and prediction recursion on the received bits rebuilds the prediction waveform. The surrounding system supplies samples and takes the serial bits.

Top module: `cvsd_encoder`

## Requirements
- R1: A sample is taken only on a clock edge where inValid is high, with sampleIn read as 16-bit two's complement. On edges where inValid is low, the step, the prediction, the bit history and outBit all keep their values.
- R2: The code bit for a sample is 1 when the sample, compared as a signed number, is greater than or equal to the prediction held before that sample. Otherwise the code bit is 0.
- R3: outValid is high for exactly the one clock after each edge on which inValid was high, and outBit presents that sample's code bit during that clock. With back-to-back strobes, outValid stays high.
- R4: A run exists when the new code bit equals each of the two code bits before it, and at least two code bits have been produced since reset. On a run, the new step is floor(step * 28016 / 32768) + 1409.
- R5: Without a run, the new step is floor(step * 28016 / 32768).
- R6: The new step is clamped from below to 32 and from above to 16384, so a steady sample makes the step settle at 32.
- R7: After the step update, the prediction gains the new step for a code bit of 1 and loses it for a code bit of 0.
- R8: The prediction saturates at +32767 and -32768 instead of wrapping. After a long run of +32767 inputs, a sample of 32000 yields a 0 bit.
- R9: A synchronous reset (rst high at a clock edge) sets the step to 1409 and the prediction to 0. It empties the bit history, so bits from before the reset never count toward a run. It also clears outValid and outBit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Marks the cycle that carries a new sample |
| sampleIn | input | 16 | Signed two's-complement voice sample |
| outValid | output | 1 | High for one clock after each accepted sample |
| outBit | output | 1 | Delta code bit for the most recent sample |

## Verification
The embedded properties take for granted that inValid is a clean level sampled at each edge, and that sampleIn is stable at any edge where inValid is high. Under those conditions, every accepted sample moves the prediction in the direction of its code bit and never wraps, and the step stays inside its clamp range. The stimulus changes inputs only on the falling clock edge, so these conditions always hold. It mixes back-to-back strobes, idle gaps and a reset in the middle of a stream. It drives full-scale inputs for long enough to pin the prediction at both rails, and holds a constant input long enough for the step to reach its floor.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;

  // Strobes passed from the control half to the datapath half
  typedef struct packed {
    logic update;  // accept the current sample this cycle
    logic bitVal;  // code bit decided for this sample
    logic runHit;  // the last RUN_LEN bits agree
  } cvsdStrobe_t;

  localparam int DEF_SAMPLE_W = 16;
  localparam int DEF_STEP_W   = 15;
  localparam int DEF_FRAC_W   = 15;
  localparam int DEF_BETA_Q   = 28016;
  localparam int DEF_BASE     = 1409;
  localparam int DEF_MIN_STEP = 32;
  localparam int DEF_MAX_STEP = 16384;
  localparam int DEF_RUN_LEN  = 3;

endpackage

// File: rtl/cvsd_ctrl.sv
module cvsd_ctrl
  import cvsd_pkg::*;
#(
  parameter int RUN_LEN = DEF_RUN_LEN
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        cmpBit,
  output cvsdStrobe_t strobe,
  output logic        outValid,
  output logic        outBit
);

  localparam int HIST_W = RUN_LEN - 1;
  localparam int FILL_W = $clog2(RUN_LEN);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(HIST_W);

  logic [HIST_W-1:0] histQ;      // histQ[0] is the most recent earlier bit
  logic [FILL_W-1:0] fillQ;      // earlier bits seen since reset, capped
  logic [HIST_W-1:0] matchVec;
  logic              fillFull;

  // Each earlier bit must agree with the newly decided one
  generate
    for (genvar i = 0; i < HIST_W; i++) begin : g_match
      assign matchVec[i] = (histQ[i] == cmpBit);
    end
  endgenerate

  assign fillFull = (fillQ == FILL_FULL);

  always_comb begin
    strobe.update = inValid;
    strobe.bitVal = cmpBit;
    strobe.runHit = inValid && fillFull && (&matchVec);
  end

  generate
    if (HIST_W > 1) begin : g_shift_multi
      always_ff @(posedge clk) begin
        if (rst) begin
          histQ <= '0;
        end else if (inValid) begin
          histQ <= {histQ[HIST_W-2:0], cmpBit};
        end
      end
    end else begin : g_shift_single
      always_ff @(posedge clk) begin
        if (rst) begin
          histQ <= '0;
        end else if (inValid) begin
          histQ <= cmpBit;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      fillQ    <= '0;
      outValid <= 1'b0;
      outBit   <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outBit <= cmpBit;
        if (!fillFull) fillQ <= fillQ + FILL_W'(1);
      end
    end
  end

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && $stable(outBit) && $stable(histQ))); // R1

  AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (rst)
    fillQ <= FILL_FULL); // R9

  AST_RUN_NEEDS_FILL: assert property (@(posedge clk) disable iff (rst)
    strobe.runHit |-> fillFull); // R4

endmodule

// File: rtl/cvsd_datapath.sv
module cvsd_datapath
  import cvsd_pkg::*;
#(
  parameter int SAMPLE_W = DEF_SAMPLE_W,
  parameter int STEP_W   = DEF_STEP_W,
  parameter int FRAC_W   = DEF_FRAC_W,
  parameter int BETA_Q   = DEF_BETA_Q,
  parameter int BASE     = DEF_BASE,
  parameter int MIN_STEP = DEF_MIN_STEP,
  parameter int MAX_STEP = DEF_MAX_STEP
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  cvsdStrobe_t                strobe,
  output logic                       cmpBit
);

  localparam int PROD_W = STEP_W + FRAC_W + 1;
  localparam int CAND_W = STEP_W + 1;
  localparam int SUM_W  = SAMPLE_W + 2;

  localparam logic [PROD_W-1:0] BETA_P = PROD_W'(BETA_Q);
  localparam logic [CAND_W-1:0] BASE_C = CAND_W'(BASE);
  localparam logic [CAND_W-1:0] MIN_C  = CAND_W'(MIN_STEP);
  localparam logic [CAND_W-1:0] MAX_C  = CAND_W'(MAX_STEP);
  localparam logic [STEP_W-1:0] MIN_S  = STEP_W'(MIN_STEP);
  localparam logic [STEP_W-1:0] MAX_S  = STEP_W'(MAX_STEP);
  localparam logic [STEP_W-1:0] INIT_S = STEP_W'(BASE);
  localparam logic signed [SUM_W-1:0] POS_LIM = SUM_W'((1 << (SAMPLE_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] NEG_LIM = ~POS_LIM;

  logic        [STEP_W-1:0]   stepQ;
  logic signed [SAMPLE_W-1:0] predQ;

  logic        [PROD_W-1:0]   prod;
  logic        [CAND_W-1:0]   decayed;
  logic        [CAND_W-1:0]   cand;
  logic        [STEP_W-1:0]   stepNext;
  logic signed [SUM_W-1:0]    predExt;
  logic signed [SUM_W-1:0]    stepExt;
  logic signed [SUM_W-1:0]    sum;
  logic signed [SAMPLE_W-1:0] predNext;

  // Comparator: decide the code bit against the held prediction
  assign cmpBit = (sampleIn >= predQ);

  // Step adapter: fixed decay, boost on a run, clamp both ways
  always_comb begin
    prod    = PROD_W'(stepQ) * BETA_P;
    decayed = prod[FRAC_W +: CAND_W];
    cand    = decayed + (strobe.runHit ? BASE_C : '0);
    if (cand < MIN_C) begin
      stepNext = MIN_S;
    end else if (cand > MAX_C) begin
      stepNext = MAX_S;
    end else begin
      stepNext = cand[STEP_W-1:0];
    end
  end

  // Integrator: move by the new step and saturate at the rails
  always_comb begin
    predExt = SUM_W'(predQ);
    stepExt = $signed({{(SUM_W - STEP_W){1'b0}}, stepNext});
    sum     = strobe.bitVal ? (predExt + stepExt) : (predExt - stepExt);
    if (sum > POS_LIM) begin
      predNext = POS_LIM[SAMPLE_W-1:0];
    end else if (sum < NEG_LIM) begin
      predNext = NEG_LIM[SAMPLE_W-1:0];
    end else begin
      predNext = sum[SAMPLE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stepQ <= INIT_S;
      predQ <= '0;
    end else if (strobe.update) begin
      stepQ <= stepNext;
      predQ <= predNext;
    end
  end

  AST_STEP_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    (stepQ >= MIN_S) && (stepQ <= MAX_S)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.update |=> ($stable(stepQ) && $stable(predQ))); // R1

  AST_RISE_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (strobe.update && strobe.bitVal) |=> (predQ >= $past(predQ))); // R8

  AST_FALL_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (strobe.update && !strobe.bitVal) |=> (predQ <= $past(predQ))); // R8

  AST_RUN_GROWS: assert property (@(posedge clk) disable iff (rst)
    (strobe.update && strobe.runHit && (stepQ <= INIT_S)) |=> (stepQ > $past(stepQ))); // R4

endmodule

// File: rtl/cvsd_encoder.sv
module cvsd_encoder
  import cvsd_pkg::*;
#(
  parameter int SAMPLE_W = DEF_SAMPLE_W,
  parameter int STEP_W   = DEF_STEP_W,
  parameter int FRAC_W   = DEF_FRAC_W,
  parameter int BETA_Q   = DEF_BETA_Q,
  parameter int BASE     = DEF_BASE,
  parameter int MIN_STEP = DEF_MIN_STEP,
  parameter int MAX_STEP = DEF_MAX_STEP,
  parameter int RUN_LEN  = DEF_RUN_LEN
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       inValid,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic                       outValid,
  output logic                       outBit
);

  cvsdStrobe_t strobe;
  logic        cmpBit;

  cvsd_ctrl #(
    .RUN_LEN (RUN_LEN)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .cmpBit   (cmpBit),
    .strobe   (strobe),
    .outValid (outValid),
    .outBit   (outBit)
  );

  cvsd_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .STEP_W   (STEP_W),
    .FRAC_W   (FRAC_W),
    .BETA_Q   (BETA_Q),
    .BASE     (BASE),
    .MIN_STEP (MIN_STEP),
    .MAX_STEP (MAX_STEP)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .sampleIn (sampleIn),
    .strobe   (strobe),
    .cmpBit   (cmpBit)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!outValid && !outBit)); // R9

endmodule

// File: tb/tb_cvsd_encoder.sv
module tb_cvsd_encoder;

  localparam int CLK_PERIOD = 10;
  localparam int N_STIM = 20;
  // Stimulus column; the expected code bits come from the bench model below
  localparam int STIM [N_STIM] = '{0, 3000, 9000, 16000, 22000, 26000, 28000,
    26000, 21000, 14000, 6000, -3000, -11000, -18000, -24000, -28000, -30000,
    -26000, -18000, -8000};

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               inValid = 1'b0;
  logic signed [15:0] sampleIn = '0;
  logic               outValid;
  logic               outBit;

  int errors = 0;
  int checks = 0;

  // Reference model state, built from the requirements
  int mPred, mStep, mFill;
  int mH1, mH2, mLastBit;

  cvsd_encoder dut (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .sampleIn (sampleIn),
    .outValid (outValid),
    .outBit   (outBit)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mPred = 0; mStep = 1409; mFill = 0; mH1 = 0; mH2 = 0; mLastBit = 0;
  endtask

  // R2 R4 R5 R6 R7 R8 in the model
  function automatic int modelStep(input int s);
    int b, run, ns, np;
    b   = (s >= mPred) ? 1 : 0;
    run = (mFill >= 2 && b == mH1 && b == mH2) ? 1 : 0;
    ns  = (mStep * 28016) >>> 15;
    if (run == 1) ns = ns + 1409;
    if (ns < 32) ns = 32;
    if (ns > 16384) ns = 16384;
    np = (b == 1) ? mPred + ns : mPred - ns;
    if (np > 32767) np = 32767;
    if (np < -32768) np = -32768;
    mStep = ns; mPred = np;
    mH2 = mH1; mH1 = b;
    if (mFill < 2) mFill++;
    mLastBit = b;
    return b;
  endfunction

  task automatic sendSample(input int s, input string req);
    int expBit;
    @(negedge clk);
    inValid  = 1'b1;
    sampleIn = 16'(s);
    expBit   = modelStep(s);
    @(posedge clk);
    #2;
    checkEq("R3", "outValid", int'(outValid), 1);
    checkEq(req, "outBit", int'(outBit), expBit);
  endtask

  task automatic idleCycle(input int junk);
    @(negedge clk);
    inValid  = 1'b0;
    sampleIn = 16'(junk);
    @(posedge clk);
    #2;
    checkEq("R3", "idle outValid", int'(outValid), 0);
    checkEq("R1", "idle outBit", int'(outBit), mLastBit);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    modelReset();
    // R9 reset state
    repeat (3) @(posedge clk);
    #2;
    checkEq("R9", "reset outValid", int'(outValid), 0);
    checkEq("R9", "reset outBit", int'(outBit), 0);
    @(negedge clk);
    rst = 1'b0;

    // Table walk: R2 R4 R5 R7 under a sine-like stream
    for (int i = 0; i < N_STIM; i++) sendSample(STIM[i], "R2");

    // Idle gaps with noisy data must change nothing: R1
    for (int i = 0; i < 3; i++) idleCycle(-20000 + i * 15000);
    for (int i = 0; i < 4; i++) sendSample(STIM[i], "R1");

    // Positive rail: long run of ones, R4 then R8
    for (int i = 0; i < 40; i++) sendSample(32767, "R4");
    sendSample(32000, "R8");
    checkEq("R8", "bit after high rail", int'(outBit), 0);

    // Negative rail
    for (int i = 0; i < 40; i++) sendSample(-32768, "R8");

    // Constant input: step decays to the floor, R5 R6
    for (int i = 0; i < 60; i++) sendSample(100, "R6");

    // Reset mid-stream after a run of ones: R9
    for (int i = 0; i < 5; i++) sendSample(30000, "R7");
    @(negedge clk);
    inValid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    #2;
    checkEq("R9", "mid reset outValid", int'(outValid), 0);
    checkEq("R9", "mid reset outBit", int'(outBit), 0);
    @(negedge clk);
    rst = 1'b0;
    modelReset();
    mLastBit = 0;
    for (int i = 0; i < 6; i++) sendSample(20000, "R9");
    for (int i = 0; i < N_STIM; i++) sendSample(STIM[N_STIM - 1 - i], "R7");
    idleCycle(0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule